// File: doc/BRIEF.md
# MMU Page Access Check

This block judges a single memory access against the three-bit protection code held in a page descriptor. Each cycle in which the access strobe is high, the block samples the protection code, the kind of access (read, write, or read-modify-write), a flag from the relocation logic that reports an access beyond the page length, and the addressing context of the operand. In the following cycle it reports whether the access must be aborted or must raise a memory-management trap. It also raises one-cycle pulses that the surrounding descriptor and status registers use to set the page's attention flag, the page's written flag and the global trap-pending flag.

Trap requests and the two statistics flags depend on both the protection code and the direction of the access. An aborted access never sets any flag and never traps. The block also chooses the instruction or data address space for the access. Only autoincrement and autoincrement-deferred operand fetches through the program counter use data space. Every other program-counter-relative operand and every instruction fetch use instruction space.

Relocation, the descriptor storage and the status registers are outside the block. It drives only the decision flags and the set pulses. All decisions are combinational from one stage of input registers.

Top module: `mmu_acf_check`

## Requirements
- R1: While reset is high, and in the first cycle after it, every decision and pulse output is low.
- R2: An access sampled with the strobe high at a rising edge produces its decision outputs during the following cycle only. A cycle sampled with the strobe low produces no abort, trap or set pulse.
- R3: An access with the page-length violation flag set is aborted whatever the protection code. It raises no trap and no set pulse.
- R4: Protection codes 0, 3 and 7 abort every access. Code 2 aborts write and read-modify-write, and lets reads pass without a trap. Code 6 lets every access pass without a trap.
- R5: Code 1 traps on a read. It aborts write and read-modify-write and never traps on them.
- R6: Code 4 traps on every access kind. Code 5 traps on write and read-modify-write, and lets reads pass without a trap.
- R7: The attention pulse and the trap-pending pulse are raised exactly when the trap condition of R5/R6 holds and the access is not aborted. An abort takes priority over a trap.
- R8: The written pulse is raised for every non-aborted access whose kind is not a read. Access kind encoding: 0 read, 1 write, 2 read-modify-write, 3 handled as read-modify-write.
- R9: The space select output is 1 for data space and 0 for instruction space. An instruction fetch selects 0. An operand access through register 7 (the program counter) selects 1 only for mode 2 (autoincrement) or mode 3 (autoincrement deferred), and 0 for every other mode, including mode 1 (deferred). An operand access through any other register selects 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| acc_stb_i | input | 1 | Access present this cycle |
| acf_i | input | 3 | Page protection code |
| acc_kind_i | input | 2 | Access kind (0 read, 1 write, 2 read-modify-write, 3 as 2) |
| len_viol_i | input | 1 | Access lies beyond the page length |
| ifetch_i | input | 1 | Access is an instruction fetch |
| amode_i | input | 3 | Operand addressing mode |
| areg_i | input | 3 | Operand register number |
| abort_o | output | 1 | Abort the access |
| trap_o | output | 1 | Request a memory-management trap |
| set_attn_o | output | 1 | Pulse: set the descriptor attention flag |
| set_wr_o | output | 1 | Pulse: set the descriptor written flag |
| set_mmtrap_o | output | 1 | Pulse: set the global trap-pending flag |
| dspace_o | output | 1 | 1 = data space, 0 = instruction space |

## Verification
The bench builds the block with its defaults: a three-bit mode field, a three-bit register field and the program counter at register index 7. With these values every protection code, every access kind and every page-length state can be swept exhaustively (64 combinations), as can every addressing mode through the program counter and through an ordinary register. Idle gaps between back-to-back strobes show that each pulse lasts exactly one cycle and that no output appears without a strobe.

// File: rtl/mmu_acf_pkg.sv
package mmu_acf_pkg;

    localparam int ACF_W  = 3;
    localparam int KIND_W = 2;

    // Protection codes with a behaviour of their own
    localparam logic [ACF_W-1:0] ACF_NONRES     = 3'd0;
    localparam logic [ACF_W-1:0] ACF_RO_TRAPRD  = 3'd1;
    localparam logic [ACF_W-1:0] ACF_RO         = 3'd2;
    localparam logic [ACF_W-1:0] ACF_RSV_A      = 3'd3;
    localparam logic [ACF_W-1:0] ACF_RW_TRAPALL = 3'd4;
    localparam logic [ACF_W-1:0] ACF_RW_TRAPWR  = 3'd5;
    localparam logic [ACF_W-1:0] ACF_RW         = 3'd6;
    localparam logic [ACF_W-1:0] ACF_RSV_B      = 3'd7;

    typedef enum logic [KIND_W-1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_RMW = 2'd2,
        ACC_RSV = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        VD_PASS  = 2'd0,
        VD_TRAP  = 2'd1,
        VD_ABORT = 2'd2
    } verdict_e;

endpackage

// File: rtl/mmu_acf_capture.sv
module mmu_acf_capture #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_o <= '0;
        end else begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/mmu_acf_decode.sv
module mmu_acf_decode
    import mmu_acf_pkg::*;
(
    input  logic [ACF_W-1:0] acf_i,
    input  acc_kind_e        kind_i,
    input  logic             len_viol_i,
    output verdict_e         verdict_o,
    output logic             wr_o
);

    logic is_wr;

    always_comb begin
        is_wr = (kind_i != ACC_RD);
    end

    always_comb begin
        verdict_o = VD_PASS;
        if (len_viol_i) begin
            verdict_o = VD_ABORT;
        end else begin
            unique case (acf_i)
                ACF_NONRES, ACF_RSV_A, ACF_RSV_B: verdict_o = VD_ABORT;
                ACF_RO_TRAPRD:  verdict_o = is_wr ? VD_ABORT : VD_TRAP;
                ACF_RO:         verdict_o = is_wr ? VD_ABORT : VD_PASS;
                ACF_RW_TRAPALL: verdict_o = VD_TRAP;
                ACF_RW_TRAPWR:  verdict_o = is_wr ? VD_TRAP : VD_PASS;
                ACF_RW:         verdict_o = VD_PASS;
                default:        verdict_o = VD_ABORT;
            endcase
        end
    end

    assign wr_o = is_wr;

endmodule

// File: rtl/mmu_space_sel.sv
module mmu_space_sel #(
    parameter int MODE_W = 3,
    parameter int REG_W  = 3,
    parameter int PC_IDX = 7
) (
    input  logic              ifetch_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [REG_W-1:0]  reg_i,
    output logic              dspace_o
);

    localparam logic [MODE_W-1:0] MODE_AINC     = MODE_W'(2);
    localparam logic [MODE_W-1:0] MODE_AINC_DEF = MODE_W'(3);
    localparam logic [REG_W-1:0]  PC_SEL        = REG_W'(PC_IDX);

    always_comb begin
        dspace_o = 1'b0;
        if (ifetch_i) begin
            dspace_o = 1'b0;
        end else if (reg_i != PC_SEL) begin
            dspace_o = 1'b1;
        end else begin
            unique case (mode_i)
                MODE_AINC, MODE_AINC_DEF: dspace_o = 1'b1;
                default:                  dspace_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/mmu_acf_check.sv
module mmu_acf_check
    import mmu_acf_pkg::*;
#(
    parameter int MODE_W = 3,
    parameter int REG_W  = 3,
    parameter int PC_IDX = 7
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              acc_stb_i,
    input  logic [2:0]        acf_i,
    input  logic [1:0]        acc_kind_i,
    input  logic              len_viol_i,
    input  logic              ifetch_i,
    input  logic [MODE_W-1:0] amode_i,
    input  logic [REG_W-1:0]  areg_i,
    output logic              abort_o,
    output logic              trap_o,
    output logic              set_attn_o,
    output logic              set_wr_o,
    output logic              set_mmtrap_o,
    output logic              dspace_o
);

    localparam int CAP_W = 1 + ACF_W + KIND_W + 1 + 1 + MODE_W + REG_W;

    logic [CAP_W-1:0]  cap_d, cap_q;
    logic              vld_q, len_q, ifetch_q;
    logic [ACF_W-1:0]  acf_q;
    logic [KIND_W-1:0] kind_q;
    logic [MODE_W-1:0] mode_q;
    logic [REG_W-1:0]  reg_q;
    verdict_e          verdict;
    logic              wr_acc;
    logic              dsel;

    assign cap_d = {acc_stb_i, acf_i, acc_kind_i, len_viol_i, ifetch_i, amode_i, areg_i};

    mmu_acf_capture #(.W(CAP_W)) u_cap (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (cap_d),
        .q_o   (cap_q)
    );

    assign {vld_q, acf_q, kind_q, len_q, ifetch_q, mode_q, reg_q} = cap_q;

    mmu_acf_decode u_dec (
        .acf_i      (acf_q),
        .kind_i     (acc_kind_e'(kind_q)),
        .len_viol_i (len_q),
        .verdict_o  (verdict),
        .wr_o       (wr_acc)
    );

    mmu_space_sel #(
        .MODE_W (MODE_W),
        .REG_W  (REG_W),
        .PC_IDX (PC_IDX)
    ) u_space (
        .ifetch_i (ifetch_q),
        .mode_i   (mode_q),
        .reg_i    (reg_q),
        .dspace_o (dsel)
    );

    // Output process: verdict to flags and one-cycle set pulses
    always_comb begin
        abort_o      = 1'b0;
        trap_o       = 1'b0;
        set_attn_o   = 1'b0;
        set_mmtrap_o = 1'b0;
        set_wr_o     = 1'b0;
        unique case (verdict)
            VD_PASS: begin
                set_wr_o = vld_q & wr_acc;
            end
            VD_TRAP: begin
                trap_o       = vld_q;
                set_attn_o   = vld_q;
                set_mmtrap_o = vld_q;
                set_wr_o     = vld_q & wr_acc;
            end
            VD_ABORT: begin
                abort_o = vld_q;
            end
            default: begin
                abort_o = vld_q;
            end
        endcase
    end

    assign dspace_o = dsel;

    // ---------------- assertions ----------------
    localparam logic [REG_W-1:0]  PC_CHK    = REG_W'(PC_IDX);
    localparam logic [MODE_W-1:0] MODE_DEFR = MODE_W'(1);

    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        $past(rst_i) |-> !(abort_o || trap_o || set_attn_o || set_wr_o || set_mmtrap_o));

    assert_no_stb_quiet_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !acc_stb_i |=> !(abort_o || trap_o || set_attn_o || set_wr_o || set_mmtrap_o));

    assert_len_abort_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_stb_i && len_viol_i) |=> (abort_o && !trap_o && !set_wr_o && !set_attn_o));

    assert_ro_write_no_trap_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_stb_i && acf_i == ACF_RO_TRAPRD && acc_kind_i != 2'd0) |=> (abort_o && !trap_o));

    assert_trap_all_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_stb_i && !len_viol_i && acf_i == ACF_RW_TRAPALL) |=> (trap_o && set_attn_o && set_mmtrap_o));

    assert_abort_wins_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        abort_o |-> !(set_attn_o || set_mmtrap_o || set_wr_o));

    assert_written_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_stb_i && !len_viol_i && acf_i == ACF_RW && acc_kind_i != 2'd0) |=> set_wr_o);

    assert_pc_defer_ispace_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_stb_i && !ifetch_i && areg_i == PC_CHK && amode_i == MODE_DEFR) |=> !dspace_o);

endmodule

// File: tb/mmu_acf_check_test.sv
module mmu_acf_check_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stb = 1'b0;
    logic [2:0] acf = '0;
    logic [1:0] kind = '0;
    logic       lenv = 1'b0;
    logic       ifet = 1'b0;
    logic [2:0] mode = '0;
    logic [2:0] rsel = '0;
    logic abort_w, trap_w, attn_w, wr_w, mmt_w, dsp_w;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [4:0] flags;   // abort, trap, attn, written, mmtrap
        logic       dsp;
        bit         chk_dsp;
        int         due;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    mmu_acf_check uut (
        .clk_i (clk), .rst_i (rst), .acc_stb_i (stb), .acf_i (acf),
        .acc_kind_i (kind), .len_viol_i (lenv), .ifetch_i (ifet),
        .amode_i (mode), .areg_i (rsel), .abort_o (abort_w), .trap_o (trap_w),
        .set_attn_o (attn_w), .set_wr_o (wr_w), .set_mmtrap_o (mmt_w),
        .dspace_o (dsp_w)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model from the requirements
    function automatic exp_t model(input logic [2:0] a, input logic [1:0] k, input logic l,
                                   input logic f, input logic [2:0] m, input logic [2:0] r);
        exp_t e;
        bit wr, ab, tc, tr;
        wr = (k != 2'd0);                                               // R8 encoding
        ab = l || a == 3'd0 || a == 3'd3 || a == 3'd7 ||
             ((a == 3'd1 || a == 3'd2) && wr);                          // R3, R4, R5
        tc = (a == 3'd1 && !wr) || a == 3'd4 || (a == 3'd5 && wr);      // R5, R6
        tr = !ab && tc;                                                 // R7
        e.flags   = {ab, tr, tr, !ab && wr, tr};
        e.dsp     = !f && (r != 3'd7 || m == 3'd2 || m == 3'd3);        // R9
        e.chk_dsp = 1'b1;
        if (l)                         e.tag = "R3";
        else if (a == 3'd1)            e.tag = "R5";
        else if (a == 3'd4 || a == 3'd5) e.tag = tr ? "R7" : "R6";
        else if (!ab && wr)            e.tag = "R8";
        else                           e.tag = "R4";
        return e;
    endfunction

    task automatic access(input logic [2:0] a, input logic [1:0] k, input logic l,
                          input logic f, input logic [2:0] m, input logic [2:0] r, input string t);
        exp_t e;
        @(negedge clk);
        stb = 1'b1; acf = a; kind = k; lenv = l; ifet = f; mode = m; rsel = r;
        e = model(a, k, l, f, m, r);
        if (t != "") e.tag = t;
        e.due = cyc + 1;
        sb.push_back(e);
    endtask

    task automatic idle();
        exp_t e;
        @(negedge clk);
        stb = 1'b0; acf = 3'd4; kind = 2'd1; lenv = 1'b0;
        e.flags = '0; e.dsp = 1'b0; e.chk_dsp = 1'b0; e.tag = "R2";
        e.due = cyc + 1;
        sb.push_back(e);
    endtask

    // Monitor: pops items when they fall due
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            logic [4:0] act;
            e = sb.pop_front();
            act = {abort_w, trap_w, attn_w, wr_w, mmt_w};
            checks++;
            if (act !== e.flags || (e.chk_dsp && dsp_w !== e.dsp)) begin
                fails++;
                $display("FAIL %s: flags=%b dsp=%b expected flags=%b dsp=%b",
                         e.tag, act, dsp_w, e.flags, e.dsp);
            end
        end
    end

    task automatic check_quiet(input string t);
        checks++;
        if ({abort_w, trap_w, attn_w, wr_w, mmt_w} !== 5'b0) begin
            fails++;
            $display("FAIL %s: flags=%b expected 00000", t,
                     {abort_w, trap_w, attn_w, wr_w, mmt_w});
        end
    endtask

    initial begin
        // R1: quiet during reset even with an access on the inputs
        stb = 1'b1; acf = 3'd4; kind = 2'd1;
        repeat (3) @(negedge clk);
        check_quiet("R1");
        stb = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_quiet("R1");

        // Exhaustive protection code x kind x length sweep (R3..R8)
        for (int l = 0; l < 2; l++)
            for (int a = 0; a < 8; a++)
                for (int k = 0; k < 4; k++)
                    access(3'(a), 2'(k), 1'(l), 1'b0, 3'd0, 3'd1, "");

        // R2: single strobes separated by gaps, pulses last one cycle
        access(3'd4, 2'd0, 1'b0, 1'b0, 3'd0, 3'd1, "R2");
        idle();
        idle();
        access(3'd5, 2'd1, 1'b0, 1'b0, 3'd0, 3'd1, "R2");
        access(3'd0, 2'd1, 1'b0, 1'b0, 3'd0, 3'd1, "R2");
        idle();

        // R9: space select across modes, registers and fetches
        for (int m = 0; m < 8; m++) begin
            access(3'd6, 2'd0, 1'b0, 1'b0, 3'(m), 3'd7, "R9");
            access(3'd6, 2'd0, 1'b0, 1'b0, 3'(m), 3'd2, "R9");
            access(3'd6, 2'd0, 1'b0, 1'b1, 3'(m), 3'd7, "R9");
        end
        idle();
        idle();
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int wd;
        wd = 0;
        while (!done && wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        if (sb.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R2: %0d results missing, expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule